// File: doc/BRIEF.md
# Serial Transmit Channel with Automatic RTS

This block is the transmit half of an asynchronous serial port. Characters written by the processor queue in a small FIFO. A framing engine takes them one at a time and puts each on the `txd` line as a low start bit, the data bits least significant first, an optional parity bit and one or two high stop bits. The line idles high. Bit timing comes from `bitTick`, a one-clock enable that an external baud generator pulses once per bit period. Each bit lasts from one tick to the next.

Each FIFO entry is 11 bits wide. Bits [8:0] carry the data. Bit 9 is a marker that can be sent in the parity slot, for 9-bit address protocols. Bit 10 requests an extra stop bit for that character only. The effective FIFO depth can be set from one to four entries.

The request-to-send output has three modes. In manual mode it follows a configuration bit. In semi-automatic and automatic modes the engine drives it. It raises the line one full bit period before the first start bit of a burst. It lowers the line either when the burst ends (semi-automatic) or when the far end also withdraws clear-to-send (automatic). Clear-to-send can also be set to hold off every character start.

Top module: `serTxChannel`

## Requirements
- R1: After reset `txd` is 1, `fifoEmpty` is 1, `fifoLevel` is 0, `overflow` is 0 and the engine-owned RTS is 0.
- R2: Each character is sent as one low start bit followed by the data bits, least significant first. Each bit spans exactly one `bitTick` period.
- R3: `cfgCharLen` selects 5 to 9 data bits. Values below 5 act as 5 and values above 9 act as 9. Entry bits above the character length never reach `txd`.
- R4: `cfgParity` 00 sends no parity bit, 01 even parity, 10 odd parity, and 11 sends entry bit 9 in the parity slot.
- R5: `cfgTwoStop`=1 sends two stop bits. An entry with bit 10 set also gets two stop bits when `cfgTwoStop`=0.
- R6: The FIFO keeps write order and accepts entries up to the effective depth. A `cfgDepth` of 0 acts as 1 and values above 4 act as 4. `fifoLevel` reports the entries held.
- R7: A write while `fifoLevel` equals the effective depth is discarded. It sets `overflow`, which stays set until reset.
- R8: With `cfgRtsMode` 00 or 11 (manual), `rtsOut` equals `cfgManualRts`. A character starts on the first tick with no lead bit.
- R9: With `cfgRtsMode` 01 (semi-automatic) or 10 (automatic), the first character after idle raises `rtsOut` on a tick. Its start bit begins exactly one tick later.
- R10: While the FIFO holds data and starting is allowed, the next start bit directly follows the last stop bit, with no lead bit.
- R11: In semi-automatic mode `rtsOut` drops at the end of the last stop bit when the FIFO is empty.
- R12: In automatic mode `rtsOut` stays high after the burst until a tick sees an empty FIFO with `ctsIn` low.
- R13: With `cfgCtsGate`=1, neither a lead bit nor a start bit begins unless `ctsIn` is 1 on that tick. Until then `txd` stays high and the FIFO keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bitTick | input | 1 | One-cycle pulse per bit period |
| wrEn | input | 1 | Write strobe for one FIFO entry |
| wrData | input | 11 | Entry: data [8:0], parity marker [9], extra stop [10] |
| cfgDepth | input | 3 | Effective FIFO depth |
| cfgCharLen | input | 4 | Data bits per character |
| cfgParity | input | 2 | Parity mode |
| cfgTwoStop | input | 1 | Two stop bits for every character |
| cfgRtsMode | input | 2 | RTS ownership mode |
| cfgManualRts | input | 1 | RTS level in manual mode |
| cfgCtsGate | input | 1 | Require `ctsIn` before starting |
| ctsIn | input | 1 | Clear-to-send from the far end, 1 = asserted |
| txd | output | 1 | Serial data line |
| rtsOut | output | 1 | Request-to-send, 1 = asserted |
| fifoLevel | output | 3 | Entries currently held |
| fifoEmpty | output | 1 | FIFO holds no entry |
| overflow | output | 1 | Sticky discarded-write flag |

## Verification
The embedded properties check, on every cycle, that:
- a discarded write leaves the level unchanged and the overflow flag never clears;
- the engine never loads from an empty FIFO;
- RTS rises only on entry to the lead bit and falls only while the engine is idle;
- a blocked clear-to-send keeps the engine idle.

Other behaviour is only visible across whole characters and bursts. This covers:
- the bit order on the line and the parity values;
- the stop-bit counts and the clamping of length and depth;
- the exact one-tick lead;
- the back-to-back framing;
- the two RTS release rules.

The bench's cycle reference model shows these under each configuration it drives.

// File: rtl/txChanPkg.sv
package txChanPkg;
  typedef enum logic [1:0] {
    LS_MARK   = 2'd0,
    LS_START  = 2'd1,
    LS_DATA   = 2'd2,
    LS_PARITY = 2'd3
  } lineSel_e;

  typedef struct packed {
    logic     load;
    logic     shift;
    lineSel_e lineSel;
  } txStrobe_t;

  localparam logic [1:0] RTS_SEMI = 2'b01;
  localparam logic [1:0] RTS_AUTO = 2'b10;

  localparam logic [1:0] PAR_NONE = 2'b00;
  localparam logic [1:0] PAR_EVEN = 2'b01;
  localparam logic [1:0] PAR_ODD  = 2'b10;
  localparam logic [1:0] PAR_TAG  = 2'b11;
endpackage

// File: rtl/txDatapath.sv
module txDatapath
  import txChanPkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int DATA_W  = 9,
  parameter int ENTRY_W = DATA_W + 2,
  parameter int LEN_W   = 4,
  parameter int LVL_W   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ENTRY_W-1:0] wrData,
  input  logic [LVL_W-1:0]   cfgDepth,
  input  logic [LEN_W-1:0]   effLen,
  input  logic [1:0]         parMode,
  input  txStrobe_t          stb,
  output logic               txd,
  output logic               fifoEmpty,
  output logic [LVL_W-1:0]   fifoLevel,
  output logic               overflow,
  output logic               chrExtraStop
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [LVL_W-1:0] MAX_LVL  = LVL_W'(DEPTH);

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]   wrPtr, rdPtr;
  logic [LVL_W-1:0]   count, effDepth;
  logic               full, push, pop;
  logic [ENTRY_W-1:0] head;
  logic [DATA_W-1:0]  lenMask, headData, shiftReg;
  logic               newPar, parBit;

  always_comb begin
    if (cfgDepth == '0)          effDepth = LVL_W'(1);
    else if (cfgDepth > MAX_LVL) effDepth = MAX_LVL;
    else                         effDepth = cfgDepth;
  end

  assign full = (count >= effDepth);
  assign push = wrEn && !full;
  assign pop  = stb.load;

  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (push && wrPtr == PTR_W'(g)) mem[g] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (push) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + PTR_W'(1);
      if (pop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + PTR_W'(1);
      count <= count + {{(LVL_W-1){1'b0}}, push} - {{(LVL_W-1){1'b0}}, pop};
      if (wrEn && full) overflow <= 1'b1;
    end
  end

  assign head = mem[rdPtr];

  always_comb begin
    for (int i = 0; i < DATA_W; i++) lenMask[i] = (i < int'(effLen));
  end

  assign headData = head[DATA_W-1:0] & lenMask;

  always_comb begin
    unique case (parMode)
      PAR_EVEN: newPar = ^headData;
      PAR_ODD:  newPar = ~^headData;
      default:  newPar = head[DATA_W];
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg     <= '0;
      parBit       <= 1'b0;
      chrExtraStop <= 1'b0;
    end else if (pop) begin
      shiftReg     <= headData;
      parBit       <= newPar;
      chrExtraStop <= head[DATA_W+1];
    end else if (stb.shift) begin
      shiftReg <= shiftReg >> 1;
    end
  end

  always_comb begin
    unique case (stb.lineSel)
      LS_START:  txd = 1'b0;
      LS_DATA:   txd = shiftReg[0];
      LS_PARITY: txd = parBit;
      default:   txd = 1'b1;
    endcase
  end

  assign fifoLevel = count;
  assign fifoEmpty = (count == '0);

  // R7
  drop_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && full && !pop) |=> (count == $past(count)));

  // R7
  sticky_ovf_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  // R6
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> (count != '0));
endmodule

// File: rtl/txControl.sv
module txControl
  import txChanPkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitTick,
  input  logic             fifoEmpty,
  input  logic [LEN_W-1:0] effLen,
  input  logic             parOn,
  input  logic             twoStop,
  input  logic             chrExtraStop,
  input  logic [1:0]       rtsMode,
  input  logic             ctsGate,
  input  logic             ctsIn,
  output txStrobe_t        stb,
  output logic             rtsAuto
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_START, ST_DATA, ST_PARITY, ST_STOP
  } state_e;

  state_e           st, stNxt;
  logic [LEN_W-1:0] bitIdx, bitIdxNxt;
  logic             stop2, stop2Nxt, rtsNxt;
  logic             semi, fullAuto, anyAuto, ctsOk, lastBit;

  assign semi     = (rtsMode == RTS_SEMI);
  assign fullAuto = (rtsMode == RTS_AUTO);
  assign anyAuto  = semi || fullAuto;
  assign ctsOk    = !ctsGate || ctsIn;
  assign lastBit  = (bitIdx == effLen - LEN_W'(1));

  always_comb begin
    stNxt     = st;
    bitIdxNxt = bitIdx;
    stop2Nxt  = stop2;
    rtsNxt    = rtsAuto;
    stb.load  = 1'b0;
    stb.shift = 1'b0;
    if (bitTick) begin
      unique case (st)
        ST_IDLE: begin
          if (!fifoEmpty && ctsOk) begin
            if (anyAuto && !rtsAuto) begin
              stNxt  = ST_LEAD;
              rtsNxt = 1'b1;
            end else begin
              stb.load = 1'b1;
              stNxt    = ST_START;
            end
          end else if (fifoEmpty && (semi || (fullAuto && !ctsIn))) begin
            rtsNxt = 1'b0;
          end
        end
        ST_LEAD: begin
          if (ctsOk) begin
            stb.load = 1'b1;
            stNxt    = ST_START;
          end
        end
        ST_START: begin
          stNxt     = ST_DATA;
          bitIdxNxt = '0;
        end
        ST_DATA: begin
          stb.shift = 1'b1;
          if (lastBit) begin
            stNxt    = parOn ? ST_PARITY : ST_STOP;
            stop2Nxt = 1'b0;
          end else begin
            bitIdxNxt = bitIdx + LEN_W'(1);
          end
        end
        ST_PARITY: begin
          stNxt    = ST_STOP;
          stop2Nxt = 1'b0;
        end
        ST_STOP: begin
          if ((twoStop || chrExtraStop) && !stop2) begin
            stop2Nxt = 1'b1;
          end else if (!fifoEmpty && ctsOk) begin
            stb.load = 1'b1;
            stNxt    = ST_START;
          end else begin
            stNxt = ST_IDLE;
            if (fifoEmpty && semi) rtsNxt = 1'b0;
          end
        end
        default: stNxt = ST_IDLE;
      endcase
    end
    if (!anyAuto) rtsNxt = 1'b0;
  end

  always_comb begin
    unique case (st)
      ST_START:  stb.lineSel = LS_START;
      ST_DATA:   stb.lineSel = LS_DATA;
      ST_PARITY: stb.lineSel = LS_PARITY;
      default:   stb.lineSel = LS_MARK;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st      <= ST_IDLE;
      bitIdx  <= '0;
      stop2   <= 1'b0;
      rtsAuto <= 1'b0;
    end else begin
      st      <= stNxt;
      bitIdx  <= bitIdxNxt;
      stop2   <= stop2Nxt;
      rtsAuto <= rtsNxt;
    end
  end

  // R9
  lead_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rtsAuto) |-> (st == ST_LEAD));

  // R11
  idle_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(rtsAuto) && anyAuto) |-> (st == ST_IDLE));

  // R13
  cts_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_IDLE && ctsGate && !ctsIn) |=> (st == ST_IDLE));

  // R3
  data_index_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_DATA) |-> (bitIdx < effLen));
endmodule

// File: rtl/serTxChannel.sv
module serTxChannel
  import txChanPkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int DATA_W  = 9,
  parameter int ENTRY_W = DATA_W + 2,
  parameter int MIN_LEN = 5
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         bitTick,
  input  logic                         wrEn,
  input  logic [ENTRY_W-1:0]           wrData,
  input  logic [$clog2(DEPTH+1)-1:0]   cfgDepth,
  input  logic [$clog2(DATA_W+1)-1:0]  cfgCharLen,
  input  logic [1:0]                   cfgParity,
  input  logic                         cfgTwoStop,
  input  logic [1:0]                   cfgRtsMode,
  input  logic                         cfgManualRts,
  input  logic                         cfgCtsGate,
  input  logic                         ctsIn,
  output logic                         txd,
  output logic                         rtsOut,
  output logic [$clog2(DEPTH+1)-1:0]   fifoLevel,
  output logic                         fifoEmpty,
  output logic                         overflow
);
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam int LEN_W = $clog2(DATA_W + 1);
  localparam logic [LEN_W-1:0] LEN_LO = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] LEN_HI = LEN_W'(DATA_W);

  txStrobe_t        stb;
  logic [LEN_W-1:0] effLen;
  logic             rtsAuto, chrExtraStop;

  always_comb begin
    if (cfgCharLen < LEN_LO)      effLen = LEN_LO;
    else if (cfgCharLen > LEN_HI) effLen = LEN_HI;
    else                          effLen = cfgCharLen;
  end

  txDatapath #(
    .DEPTH(DEPTH), .DATA_W(DATA_W), .ENTRY_W(ENTRY_W),
    .LEN_W(LEN_W), .LVL_W(LVL_W)
  ) uPath (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .cfgDepth(cfgDepth), .effLen(effLen), .parMode(cfgParity), .stb(stb),
    .txd(txd), .fifoEmpty(fifoEmpty), .fifoLevel(fifoLevel),
    .overflow(overflow), .chrExtraStop(chrExtraStop)
  );

  txControl #(.LEN_W(LEN_W)) uCtrl (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .fifoEmpty(fifoEmpty),
    .effLen(effLen), .parOn(cfgParity != PAR_NONE), .twoStop(cfgTwoStop),
    .chrExtraStop(chrExtraStop), .rtsMode(cfgRtsMode), .ctsGate(cfgCtsGate),
    .ctsIn(ctsIn), .stb(stb), .rtsAuto(rtsAuto)
  );

  assign rtsOut = (cfgRtsMode == RTS_SEMI || cfgRtsMode == RTS_AUTO) ? rtsAuto : cfgManualRts;
endmodule

// File: tb/tb_serTxChannel.sv
module tb_serTxChannel;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;

  logic clk = 0, rstN = 0, bitTick = 0, wrEn = 0;
  logic [10:0] wrData = '0;
  logic [2:0]  cfgDepth = 3'd4;
  logic [3:0]  cfgCharLen = 4'd8;
  logic [1:0]  cfgParity = 2'b00, cfgRtsMode = 2'b00;
  logic        cfgTwoStop = 0, cfgManualRts = 0, cfgCtsGate = 0, ctsIn = 0;
  logic        txd, rtsOut, fifoEmpty, overflow;
  logic [2:0]  fifoLevel;

  serTxChannel dut (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .wrEn(wrEn), .wrData(wrData),
    .cfgDepth(cfgDepth), .cfgCharLen(cfgCharLen), .cfgParity(cfgParity),
    .cfgTwoStop(cfgTwoStop), .cfgRtsMode(cfgRtsMode), .cfgManualRts(cfgManualRts),
    .cfgCtsGate(cfgCtsGate), .ctsIn(ctsIn), .txd(txd), .rtsOut(rtsOut),
    .fifoLevel(fifoLevel), .fifoEmpty(fifoEmpty), .overflow(overflow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    total = 0, bad = 0, tickCnt = 0;
  string curReq = "R1";

  always @(negedge clk) begin
    tickCnt = (tickCnt + 1) % TICK_DIV;
    bitTick <= (tickCnt == 0);
  end

  // behavioural reference: states 0 idle,1 lead,2 start,3 data,4 parity,5 stop
  logic [10:0] q[$];
  int   mSt = 0, mIdx = 0;
  bit   mStop2 = 0, mRts = 0, mOvf = 0, mPar = 0, mExtra = 0;
  logic [8:0] mShift = '0;

  task automatic modelStep();
    int eDepth, eLen;
    bit empty, full, ctsOk, semi, autoF, doPop;
    logic [10:0] e;
    logic [8:0] d;
    eDepth = (cfgDepth == 0) ? 1 : (cfgDepth > 4) ? 4 : int'(cfgDepth);
    eLen   = (cfgCharLen < 5) ? 5 : (cfgCharLen > 9) ? 9 : int'(cfgCharLen);
    empty  = (q.size() == 0);
    full   = (q.size() >= eDepth);
    ctsOk  = !cfgCtsGate || ctsIn;
    semi   = (cfgRtsMode == 2'b01);
    autoF  = (cfgRtsMode == 2'b10);
    doPop  = 0;
    if (bitTick) begin
      case (mSt)
        0: if (!empty && ctsOk) begin
             if ((semi || autoF) && !mRts) begin mSt = 1; mRts = 1; end
             else begin doPop = 1; mSt = 2; end
           end else if (empty && (semi || (autoF && !ctsIn))) mRts = 0;
        1: if (ctsOk) begin doPop = 1; mSt = 2; end
        2: begin mSt = 3; mIdx = 0; end
        3: begin
             mShift = mShift >> 1;
             if (mIdx == eLen - 1) begin mSt = (cfgParity != 0) ? 4 : 5; mStop2 = 0; end
             else mIdx++;
           end
        4: begin mSt = 5; mStop2 = 0; end
        default: begin
          if ((cfgTwoStop || mExtra) && !mStop2) mStop2 = 1;
          else if (!empty && ctsOk) begin doPop = 1; mSt = 2; end
          else begin mSt = 0; if (empty && semi) mRts = 0; end
        end
      endcase
    end
    if (!(semi || autoF)) mRts = 0;
    if (doPop) begin
      e = q.pop_front();
      d = '0;
      for (int i = 0; i < eLen; i++) d[i] = e[i];
      mShift = d;
      mExtra = e[10];
      case (cfgParity)
        2'b01:   mPar = ^d;
        2'b10:   mPar = ~^d;
        default: mPar = e[9];
      endcase
    end
    if (wrEn) begin
      if (!full) q.push_back(wrData);
      else mOvf = 1;
    end
  endtask

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    int expTxd;
    expTxd = (mSt == 2) ? 0 : (mSt == 3) ? int'(mShift[0]) : (mSt == 4) ? int'(mPar) : 1;
    check(curReq, "txd", int'(txd), expTxd);
    check(curReq, "rtsOut", int'(rtsOut),
          (cfgRtsMode == 2'b01 || cfgRtsMode == 2'b10) ? int'(mRts) : int'(cfgManualRts));
    check(curReq, "fifoLevel", int'(fifoLevel), q.size());
    check(curReq, "fifoEmpty", int'(fifoEmpty), int'(q.size() == 0));
    check(curReq, "overflow", int'(overflow), int'(mOvf));
  endtask

  always @(posedge clk) begin
    if (rstN) modelStep();
    else begin
      q.delete(); mSt = 0; mIdx = 0; mStop2 = 0; mRts = 0; mOvf = 0;
      mPar = 0; mExtra = 0; mShift = '0;
    end
    #1;
    if (rstN) compareAll();
  end

  task automatic put(logic [10:0] v);
    @(negedge clk); wrEn = 1; wrData = v;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic waitCycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    while (!fifoEmpty) @(negedge clk);
    waitCycles(TICK_DIV * 16);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL %s watchdog act=running exp=finished", curReq);
    summary();
    $finish;
  end

  initial begin
    int n;
    waitCycles(4);
    // R1 reset state
    check("R1", "txd", int'(txd), 1);
    check("R1", "fifoEmpty", int'(fifoEmpty), 1);
    check("R1", "fifoLevel", int'(fifoLevel), 0);
    check("R1", "overflow", int'(overflow), 0);
    check("R1", "rtsOut", int'(rtsOut), 0);
    rstN = 1;
    waitCycles(3);

    curReq = "R2";
    put(11'h0A5); put(11'h13C); drain();

    curReq = "R8";
    cfgManualRts = 1; waitCycles(1);
    check("R8", "rtsOut manual", int'(rtsOut), 1);
    put(11'h055); drain();
    cfgManualRts = 0;

    curReq = "R3";
    cfgCharLen = 4'd5;  put(11'h1FF); drain();
    cfgCharLen = 4'd9;  put(11'h1A5); drain();
    cfgCharLen = 4'd12; put(11'h155); drain();
    cfgCharLen = 4'd2;  put(11'h0F6); drain();

    curReq = "R4";
    cfgCharLen = 4'd7;
    cfgParity = 2'b01; put(11'h035); put(11'h034); drain();
    cfgParity = 2'b10; put(11'h035); put(11'h034); drain();
    cfgParity = 2'b11; put(11'h235); put(11'h035); drain();

    curReq = "R5";
    cfgParity = 2'b00; cfgCharLen = 4'd8;
    cfgTwoStop = 1; put(11'h0C3); put(11'h03C); drain();
    cfgTwoStop = 0; put(11'h4AA); put(11'h055); drain();

    curReq = "R7";
    cfgCtsGate = 1; ctsIn = 0; cfgDepth = 3'd2;
    put(11'h011); put(11'h022); put(11'h033);
    waitCycles(1);
    check("R6", "level at depth 2", int'(fifoLevel), 2);
    check("R7", "overflow after drop", int'(overflow), 1);
    curReq = "R13";
    waitCycles(TICK_DIV * 5);
    check("R13", "txd held", int'(txd), 1);
    check("R13", "level held", int'(fifoLevel), 2);
    ctsIn = 1; drain();

    curReq = "R6";
    ctsIn = 0; cfgDepth = 3'd0;
    put(11'h044); put(11'h055);
    waitCycles(1);
    check("R6", "depth 0 acts as 1", int'(fifoLevel), 1);
    cfgDepth = 3'd7;
    put(11'h066); put(11'h077); put(11'h088); put(11'h099);
    waitCycles(1);
    check("R6", "depth 7 acts as 4", int'(fifoLevel), 4);
    ctsIn = 1; drain();
    cfgCtsGate = 0; ctsIn = 0; cfgDepth = 3'd4;

    curReq = "R9";
    cfgRtsMode = 2'b01;
    put(11'h0A1);
    while (!rtsOut) @(negedge clk);
    n = 0;
    while (txd && n < 100) begin @(negedge clk); n++; end
    check("R9", "lead cycles", n, TICK_DIV);
    curReq = "R10";
    put(11'h0B2); put(11'h0C3);
    while (!fifoEmpty) @(negedge clk);
    curReq = "R11";
    waitCycles(TICK_DIV * 16);
    check("R11", "semi rts released", int'(rtsOut), 0);

    curReq = "R12";
    cfgRtsMode = 2'b10; ctsIn = 1;
    put(11'h05A); drain();
    waitCycles(TICK_DIV * 4);
    check("R12", "auto rts held", int'(rtsOut), 1);
    ctsIn = 0;
    waitCycles(TICK_DIV * 2 + 2);
    check("R12", "auto rts released", int'(rtsOut), 0);

    summary();
    $finish;
  end
endmodule